// File: doc/BRIEF.md
# Watch Timer with Buzzer Tone Output

This block divides the system clock into a slow watch base tick. The base tick drives a binary divider chain. That single chain does two jobs. It raises an interval request flag at one of two selectable periods, and it supplies a square-wave tone to a buzzer pin at one of four selectable frequencies. With the default settings the system clock is 4.19 MHz and the prescaler divides it by 128, which gives a 32.768 kHz base. On that base the two intervals are 0.5 s (16384 base ticks) and 3.91 ms (128 base ticks). The four tones are 16, 8, 4 and 2 kHz.

Software controls the block through an 8-bit mode register, written over a one-cycle write strobe. The request flag is a quasi-interrupt: it stays set until software pulses the clear input. A clock-enable input qualifies every system clock that the prescaler counts, so a paused system clock also pauses the whole timer.

Top module: `watchBuzzer`

## Requirements
- R1: After reset the mode register holds 0 (timer off), the request flag is 0 and the buzzer output is 0.
- R2: While the timer is on, one base tick occurs for every PRESCALE cycles in which clkEn is high; cycles with clkEn low do not advance the prescaler or the chain.
- R3: With mode bit 1 = 1 (short interval), the flag is set after every SHORT_TICKS base ticks; the first set after the timer is switched on comes on the SHORT_TICKS*PRESCALE-th counted cycle.
- R4: With mode bit 1 = 0 (long interval), the flag is set after every LONG_TICKS base ticks.
- R5: Once set, the flag stays at 1 until irqClr is high for a cycle in which no interval ends; it reads 0 from the next cycle on.
- R6: When irqClr is high in the same cycle that an interval ends, the flag is 1 after that cycle.
- R7: Mode bits [3:2] = n select a tone: a 50 % duty square wave with a period of 2^(n+1) base ticks. It is low for the first 2^n ticks after the chain is at zero. So n=0,1,2,3 give base/2, /4, /8 and /16.
- R8: With mode bit 4 = 0 the buzzer output is held at 0, while interval requests continue.
- R9: With mode bit 0 = 0 the prescaler and the chain are held at zero, the buzzer output is 0 and no new request is raised; the flag keeps its value. Switching back on restarts the count from zero.
- R10: A mode write takes effect from the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Qualifies a system clock cycle for counting |
| modeWe | input | 1 | Write strobe for the mode register |
| modeData | input | 8 | Mode value: bit0 on, bit1 short interval, bits[3:2] tone, bit4 buzzer on, bits[7:5] unused |
| irqClr | input | 1 | Clears the request flag |
| irqFlag | output | 1 | Interval request flag |
| buzzOut | output | 1 | Buzzer square-wave output |

## Verification
A behavioural model counts base ticks as an integer and predicts the flag and buzzer level for every cycle. Its results are compared while the bench runs these patterns: a steady clock enable, a clock enable that is low one cycle in three, each of the four tones, a buzzer switched off, both interval lengths, a clear held high through interval ends, and a switch-off with a later restart. The steady and gapped enable patterns separate correct prescaling from a prescaler that counts every clock. The held clear separates set-over-clear priority from clear-over-set. Cycle-exact checks on the first request after power-on and after a restart separate a chain that is reset on switch-off from one that is merely frozen.

// File: rtl/wbPkg.sv
package wbPkg;

  localparam int NUM_TONES = 4;

  // mode register layout, MSB first
  typedef struct packed {
    logic [2:0] spare;
    logic       buzzEn;
    logic [1:0] toneSel;
    logic       shortSel;
    logic       enable;
  } wbMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       run;
    logic       tick;
    logic       shortSel;
    logic [1:0] toneSel;
    logic       buzzEn;
  } wbStrobe_t;

endpackage

// File: rtl/wbCtrl.sv
module wbCtrl
  import wbPkg::*;
#(
  parameter int PRESCALE = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       modeWe,
  input  logic [7:0] modeData,
  output wbStrobe_t  strobe
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  wbMode_t          modeReg;
  logic [PRE_W-1:0] preCnt;
  logic             preWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
    end else if (modeWe) begin
      modeReg <= wbMode_t'(modeData);
    end
  end

  assign preWrap = modeReg.enable && clkEn && (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!modeReg.enable) begin
      preCnt <= '0;
    end else if (clkEn) begin
      if (preCnt == PRE_LAST) begin
        preCnt <= '0;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.run      = modeReg.enable;
    strobe.tick     = preWrap;
    strobe.shortSel = modeReg.shortSel;
    strobe.toneSel  = modeReg.toneSel;
    strobe.buzzEn   = modeReg.buzzEn;
  end

endmodule

// File: rtl/wbDatapath.sv
module wbDatapath
  import wbPkg::*;
#(
  parameter int LONG_TICKS  = 16384,
  parameter int SHORT_TICKS = 128
) (
  input  logic      clk,
  input  logic      rstN,
  input  wbStrobe_t strobe,
  input  logic      irqClr,
  output logic      irqFlag,
  output logic      buzzOut,
  output logic      hit,
  output logic      chainZero
);

  localparam int DIV_W   = $clog2(LONG_TICKS);
  localparam int SHORT_W = $clog2(SHORT_TICKS);

  logic [DIV_W-1:0]     chain;
  logic [NUM_TONES-1:0] tapVec;
  logic                 shortEnd;
  logic                 longEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else if (!strobe.run) begin
      chain <= '0;
    end else if (strobe.tick) begin
      chain <= chain + 1'b1;
    end
  end

  // tone taps: bit g toggles every 2^g ticks
  for (genvar g = 0; g < NUM_TONES; g++) begin : g_tap
    assign tapVec[g] = chain[g];
  end

  assign buzzOut   = strobe.run && strobe.buzzEn && tapVec[strobe.toneSel];
  assign shortEnd  = &chain[SHORT_W-1:0];
  assign longEnd   = &chain;
  assign hit       = strobe.tick && (strobe.shortSel ? shortEnd : longEnd);
  assign chainZero = (chain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (hit) begin
      irqFlag <= 1'b1;
    end else if (irqClr) begin
      irqFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/watchBuzzer.sv
module watchBuzzer
  import wbPkg::*;
#(
  parameter int PRESCALE    = 128,
  parameter int LONG_TICKS  = 16384,
  parameter int SHORT_TICKS = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       modeWe,
  input  logic [7:0] modeData,
  input  logic       irqClr,
  output logic       irqFlag,
  output logic       buzzOut
);

  wbStrobe_t strobe;
  logic      hitW;
  logic      chainZeroW;
  logic      tickW;
  logic      runW;
  logic      buzzEnW;

  wbCtrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .modeWe   (modeWe),
    .modeData (modeData),
    .strobe   (strobe)
  );

  wbDatapath #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .irqClr    (irqClr),
    .irqFlag   (irqFlag),
    .buzzOut   (buzzOut),
    .hit       (hitW),
    .chainZero (chainZeroW)
  );

  assign tickW   = strobe.tick;
  assign runW    = strobe.run;
  assign buzzEnW = strobe.buzzEn;

endmodule

// File: rtl/wbChecker.sv
module wbChecker (
  input logic clk,
  input logic rstN,
  input logic irqClr,
  input logic irqFlag,
  input logic buzzOut,
  input logic hit,
  input logic tick,
  input logic run,
  input logic buzzEn,
  input logic chainZero
);

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  p_hit_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> tick);

  p_hit_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> irqFlag);

  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && irqClr && !hit) |=> !irqFlag);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!irqFlag && !hit) |=> !irqFlag);

  p_buzz_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    buzzOut |-> (run && buzzEn));

  p_off_resets_r9: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> chainZero);

endmodule

bind watchBuzzer wbChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqClr    (irqClr),
  .irqFlag   (irqFlag),
  .buzzOut   (buzzOut),
  .hit       (hitW),
  .tick      (tickW),
  .run       (runW),
  .buzzEn    (buzzEnW),
  .chainZero (chainZeroW)
);

// File: tb/watchBuzzer_tb.sv
`timescale 1ns/1ps
module watchBuzzer_tb;

  localparam int P  = 4;
  localparam int SH = 8;
  localparam int LG = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b1;
  logic       modeWe = 1'b0;
  logic [7:0] modeData = 8'h00;
  logic       irqClr = 1'b0;
  logic       irqFlag;
  logic       buzzOut;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";

  // behavioural reference state
  int mEn = 0, mShort = 0, mTone = 0, mBuzz = 0;
  int pre = 0, ticks = 0, mFlag = 0;

  always #5 clk = ~clk;

  watchBuzzer #(.PRESCALE(P), .LONG_TICKS(LG), .SHORT_TICKS(SH)) u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .modeWe(modeWe),
    .modeData(modeData), .irqClr(irqClr), .irqFlag(irqFlag), .buzzOut(buzzOut)
  );

  always @(posedge clk) begin
    int hitNow;
    if (!rstN) begin
      mEn = 0; mShort = 0; mTone = 0; mBuzz = 0;
      pre = 0; ticks = 0; mFlag = 0;
    end else begin
      hitNow = 0;
      if (mEn == 0) begin
        pre = 0; ticks = 0;
      end else if (clkEn) begin
        if (pre == P - 1) begin
          pre = 0;
          ticks = (ticks + 1) % LG;
          if (ticks % (mShort != 0 ? SH : LG) == 0) hitNow = 1;
        end else begin
          pre = pre + 1;
        end
      end
      if (hitNow != 0) mFlag = 1;
      else if (irqClr) mFlag = 0;
      if (modeWe) begin
        mEn = modeData[0]; mShort = modeData[1];
        mTone = modeData[3:2]; mBuzz = modeData[4];
      end
    end
  end

  function automatic int expBuzz();
    return (mEn != 0 && mBuzz != 0) ? ((ticks >> mTone) & 1) : 0;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(curReq, int'(irqFlag), mFlag, "flag vs model");
    check(curReq, int'(buzzOut), expBuzz(), "buzz vs model");
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeMode(logic [7:0] d);
    modeWe = 1'b1; modeData = d;
    cyc(1);
    modeWe = 1'b0;
  endtask

  task automatic clearFlag();
    irqClr = 1'b1; cyc(1); irqClr = 1'b0;
  endtask

  // mode bits: 0 on, 1 short, 3:2 tone, 4 buzzer on
  function automatic logic [7:0] md(int en, int sh, int tone, int bz);
    return {3'b000, bz[0], tone[1:0], sh[0], en[0]};
  endfunction

  initial begin
    int flagHigh;
    cyc(3);
    check("R1", int'(irqFlag), 0, "reset flag");
    check("R1", int'(buzzOut), 0, "reset buzz");
    rstN = 1'b1;
    cyc(2);
    check("R1", int'(buzzOut), 0, "buzz while off");

    // R3: first request exactly after SH*P counted cycles
    curReq = "R3";
    writeMode(md(1, 1, 0, 1));
    cyc(SH * P - 1);
    check("R3", int'(irqFlag), 0, "flag one cycle before first interval");
    cyc(1);
    check("R3", int'(irqFlag), 1, "flag at first interval");
    cyc(10);
    check("R5", int'(irqFlag), 1, "flag held without clear");

    curReq = "R5";
    clearFlag();
    check("R5", int'(irqFlag), 0, "flag after clear");

    // R7: every tone
    curReq = "R7";
    for (int t = 0; t < 4; t++) begin
      writeMode(md(1, 1, t, 1));
      cyc(80);
    end

    // R10: tone changed mid-run
    curReq = "R10";
    writeMode(md(1, 1, 1, 1));
    cyc(5);
    writeMode(md(1, 1, 2, 1));
    cyc(20);

    // R8: buzzer gated off
    curReq = "R8";
    clearFlag();
    writeMode(md(1, 1, 0, 0));
    cyc(80);
    check("R8", int'(buzzOut), 0, "buzz with buzzer bit off");
    check("R8", int'(irqFlag), 1, "requests continue with buzzer off");

    // R2: gapped clock enable
    curReq = "R2";
    writeMode(md(1, 1, 0, 1));
    for (int i = 0; i < 240; i++) begin
      clkEn = (i % 3 != 2);
      if (i % 50 == 0) irqClr = 1'b1; else irqClr = 1'b0;
      cyc(1);
    end
    clkEn = 1'b1; irqClr = 1'b0;

    // R4: long interval
    curReq = "R4";
    writeMode(md(1, 0, 3, 1));
    clearFlag();
    cyc(LG * P + 40);
    check("R4", int'(irqFlag), 1, "long interval reached");

    // R6: clear held through interval ends
    curReq = "R6";
    writeMode(md(1, 1, 0, 1));
    irqClr = 1'b1;
    flagHigh = 0;
    for (int i = 0; i < 100; i++) begin
      cyc(1);
      if (irqFlag) flagHigh++;
    end
    irqClr = 1'b0;
    check("R6", (flagHigh >= 2) ? 1 : 0, 1, "set wins over clear");

    // R9: switch off keeps flag, silences buzzer, restarts from zero
    curReq = "R9";
    cyc(SH * P + 4);
    writeMode(md(0, 1, 0, 1));
    cyc(60);
    check("R9", int'(irqFlag), 1, "flag kept while off");
    check("R9", int'(buzzOut), 0, "buzz while off");
    clearFlag();
    cyc(SH * P + 4);
    check("R9", int'(irqFlag), 0, "no request while off");
    writeMode(md(1, 1, 0, 1));
    cyc(SH * P - 1);
    check("R9", int'(irqFlag), 0, "restart one cycle before interval");
    cyc(1);
    check("R9", int'(irqFlag), 1, "restart interval from zero");
    cyc(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule